// File: doc/BRIEF.md
# Bus Target Initialization and System-Error Control Register

This block is a small control register owned by the local processor of a bus target device. It decides whether the device may take part in bus traffic, and it handles the system-error line in both directions. A ready flag keeps the device in a holding state after reset. In that state every configuration cycle aimed at the device is answered with a retry, and device select is withheld for configuration, I/O and memory commands alike. Local firmware loads its other setup state and then sets the flag. From that point configuration cycles get a normal response and the device claims commands as usual.

The same register lets firmware raise a system error. Each rising transition of a request bit produces a single one-cycle low pulse on the active-low error output. The pulse is produced only if the device is not the central function and the bus command register has its error-reporting enable set. In the other direction, an external error seen on the bus is passed through a two-stage synchronizer. When the device is the central function, that error sets a sticky status flag. Software clears the flag by writing a 1 to it. The flag, gated by an interrupt enable, drives an interrupt request to the processor.

Top module: `bus_init_serr_ctrl`

## Requirements
- R1: After reset, every register bit reads 0, `cfg_retry` is 1, `devsel_allow` is 0, `serr_out_n` is 1 and `serr_irq` is 0.
- R2: Bit 0 (ready flag) is read/write. While it reads 0, `cfg_retry` is 1 and `devsel_allow` is 0.
- R3: A write with bit 0 set makes `cfg_retry` 0 and `devsel_allow` 1 from the first cycle after the write edge.
- R4: Bit 1 (error request) is read/write. When it goes from 0 to 1 at write edge k, `serr_out_n` is low for exactly the one cycle after edge k+1. This happens only if `central_fn` was 0 and `cmd_serr_en` was 1 during the cycle between edges k and k+1.
- R5: No pulse is produced when that condition is not met. Writing 1 while bit 1 already reads 1 produces no further pulse.
- R6: Bit 2 and all bits above bit 3 always read 0.
- R7: Bit 3 (error seen) becomes 1 three edges after `serr_in_n` goes low, provided `central_fn` is 1 at the third edge. It is not set while `central_fn` is 0.
- R8: Writing 1 to bit 3 clears it and writing 0 leaves it unchanged. If a new error-set condition occurs at the same edge as a clearing write, the bit stays 1.
- R9: `serr_irq` equals bit 3 ANDed with `irq_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 4 | Write data for bits 3:0 |
| rd_data | output | DATA_W | Register read value |
| central_fn | input | 1 | High when this device is the central bus function |
| cmd_serr_en | input | 1 | Error-reporting enable from the bus command register |
| serr_in_n | input | 1 | Asynchronous active-low system error seen on the bus |
| serr_out_n | output | 1 | Active-low system error pulse driven by this device |
| cfg_retry | output | 1 | Retry configuration cycles aimed at this device |
| devsel_allow | output | 1 | Device select may be asserted |
| irq_en | input | 1 | Interrupt enable for the error-seen flag |
| serr_irq | output | 1 | Interrupt request to the local processor |

## Verification
A stuck or wrongly cleared ready flag appears on `cfg_retry` and `devsel_allow` in the first cycle after the write. A bad edge detector shows up as a missing, doubled or unqualified low cycle on `serr_out_n` exactly two edges after the write. Synchronizer or sticky-flag faults move or drop the rise of bit 3 and of `serr_irq` relative to the third edge after `serr_in_n` falls. A lost set during a simultaneous clear shows as bit 3 reading 0 in the very next cycle.

// File: rtl/bisc_pkg.sv
// Package: shared field positions and widths for the init/error control register.
// Assumes the register presents four meaningful low bits.
package bisc_pkg;
    localparam int FIELD_W   = 4;
    localparam int BIT_READY = 0;
    localparam int BIT_REQ   = 1;
    localparam int BIT_RSVD  = 2;
    localparam int BIT_SEEN  = 3;

    typedef struct packed {
        logic seen;
        logic rsvd;
        logic req;
        logic ready;
    } ctrl_fields_t;
endpackage

// File: rtl/bisc_sync.sv
// Module: multi-stage synchronizer for an asynchronous level.
// Assumes the input is an active-low level; all stages reset to the idle value RST_VAL.
module bisc_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    // Shift the asynchronous level through the stage chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= {STAGES{RST_VAL}};
        end else begin
            chain <= {chain[STAGES-2:0], d_async};
        end
    end

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/bisc_serr_pulse.sv
// Module: turns a rising edge of the request bit into a single low cycle on the error output.
// Assumes the qualification inputs are sampled at the edge that detects the rise.
module bisc_serr_pulse (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic central_fn,
    input  logic cmd_serr_en,
    output logic serr_out_n
);
    logic req_q;
    logic fire;

    // Edge qualification: a new request, not the central function, and reporting enabled.
    always_comb begin
        fire = req && !req_q && !central_fn && cmd_serr_en;
    end

    // Remember the previous request level and register the pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q      <= 1'b0;
            serr_out_n <= 1'b1;
        end else begin
            req_q      <= req;
            serr_out_n <= !fire;
        end
    end
endmodule

// File: rtl/bisc_ctrl_reg.sv
// Module: holds the ready and request bits plus the sticky error-seen flag.
// Assumes err_low is already synchronous; a set in the same cycle as a clear wins.
module bisc_ctrl_reg
    import bisc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [FIELD_W-1:0] wr_data,
    input  logic               err_low,
    input  logic               central_fn,
    output ctrl_fields_t       fields
);
    logic ready_q;
    logic req_q;
    logic seen_q;
    logic seen_set;
    logic seen_clr;

    // Decode the set and clear conditions of the sticky flag.
    always_comb begin
        seen_set = err_low && central_fn;
        seen_clr = wr_en && wr_data[BIT_SEEN];
    end

    // Load the read/write bits and update the sticky flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready_q <= 1'b0;
            req_q   <= 1'b0;
            seen_q  <= 1'b0;
        end else begin
            if (wr_en) begin
                ready_q <= wr_data[BIT_READY];
                req_q   <= wr_data[BIT_REQ];
            end
            if (seen_set) begin
                seen_q <= 1'b1;
            end else if (seen_clr) begin
                seen_q <= 1'b0;
            end
        end
    end

    // Present the fields; the reserved bit is tied low.
    always_comb begin
        fields.ready = ready_q;
        fields.req   = req_q;
        fields.rsvd  = 1'b0;
        fields.seen  = seen_q;
    end

    logic unused_wr;
    assign unused_wr = wr_data[BIT_RSVD];
endmodule

// File: rtl/bus_init_serr_ctrl.sv
// Module: top of the init and system-error control register.
// Assumes a single clock domain except serr_in_n, which is synchronized here.
module bus_init_serr_ctrl
    import bisc_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [FIELD_W-1:0] wr_data,
    output logic [DATA_W-1:0]  rd_data,
    input  logic               central_fn,
    input  logic               cmd_serr_en,
    input  logic               serr_in_n,
    output logic               serr_out_n,
    output logic               cfg_retry,
    output logic               devsel_allow,
    input  logic               irq_en,
    output logic               serr_irq
);
    localparam int PAD_W = DATA_W - FIELD_W;

    ctrl_fields_t fields;
    logic         serr_sync_n;

    bisc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (serr_in_n),
        .q_sync  (serr_sync_n)
    );

    bisc_ctrl_reg u_reg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .err_low    (!serr_sync_n),
        .central_fn (central_fn),
        .fields     (fields)
    );

    bisc_serr_pulse u_pulse (
        .clk         (clk),
        .rst_n       (rst_n),
        .req         (fields.req),
        .central_fn  (central_fn),
        .cmd_serr_en (cmd_serr_en),
        .serr_out_n  (serr_out_n)
    );

    // Derive the bus-side controls, the interrupt request and the read word.
    always_comb begin
        cfg_retry    = !fields.ready;
        devsel_allow = fields.ready;
        serr_irq     = fields.seen && irq_en;
        rd_data      = {{PAD_W{1'b0}}, fields};
    end
endmodule

// File: rtl/bisc_checker.sv
// Module: assertions over the ports of bus_init_serr_ctrl, attached by bind.
module bisc_checker #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [3:0]        wr_data,
    input logic [DATA_W-1:0] rd_data,
    input logic              central_fn,
    input logic              cmd_serr_en,
    input logic              serr_out_n,
    input logic              cfg_retry,
    input logic              devsel_allow,
    input logic              irq_en,
    input logic              serr_irq
);
    assert_ready_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !wr_data[0] |=> cfg_retry && !devsel_allow);

    assert_ready_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_data[0] |=> !cfg_retry && devsel_allow);

    assert_pulse_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !serr_out_n |=> serr_out_n);

    assert_pulse_qualified_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(serr_out_n) |-> $past(!central_fn && cmd_serr_en && rd_data[1]));

    assert_seen_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[3] && !(wr_en && wr_data[3]) |=> rd_data[3]);

    assert_irq_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
        serr_irq |-> rd_data[3] && irq_en);
endmodule

bind bus_init_serr_ctrl bisc_checker #(.DATA_W(DATA_W)) u_bisc_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .rd_data      (rd_data),
    .central_fn   (central_fn),
    .cmd_serr_en  (cmd_serr_en),
    .serr_out_n   (serr_out_n),
    .cfg_retry    (cfg_retry),
    .devsel_allow (devsel_allow),
    .irq_en       (irq_en),
    .serr_irq     (serr_irq)
);

// File: tb/bus_init_serr_ctrl_bench.sv
module bus_init_serr_ctrl_bench;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [3:0]    wr_data = '0;
    logic [DW-1:0] rd_data;
    logic          central_fn = 1'b0;
    logic          cmd_serr_en = 1'b0;
    logic          serr_in_n = 1'b1;
    logic          serr_out_n;
    logic          cfg_retry;
    logic          devsel_allow;
    logic          irq_en = 1'b0;
    logic          serr_irq;

    int total = 0;
    int bad = 0;

    // Reference state, updated once per rising edge from the requirements.
    logic m_ready, m_req, m_req_d, m_pulse, m_s1, m_s2, m_seen;

    always #5 clk = ~clk;

    bus_init_serr_ctrl #(.DATA_W(DW)) u_bus_init_serr_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .central_fn(central_fn), .cmd_serr_en(cmd_serr_en),
        .serr_in_n(serr_in_n), .serr_out_n(serr_out_n), .cfg_retry(cfg_retry),
        .devsel_allow(devsel_allow), .irq_en(irq_en), .serr_irq(serr_irq)
    );

    function automatic logic [DW-1:0] exp_word(logic rd, logic rq, logic sn);
        logic [DW-1:0] w;
        w = '0;
        w[0] = rd;
        w[1] = rq;
        w[3] = sn;
        return w;
    endfunction

    task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_ready = 0; m_req = 0; m_req_d = 0; m_pulse = 0;
        m_s1 = 1; m_s2 = 1; m_seen = 0;
    endtask

    // Advance one edge with the driven inputs, update the model, then compare at the falling edge.
    task automatic step();
        logic n_pulse, n_seen;
        @(posedge clk);
        n_pulse = m_req && !m_req_d && !central_fn && cmd_serr_en;
        n_seen  = (!m_s2 && central_fn) || (m_seen && !(wr_en && wr_data[3]));
        m_req_d = m_req;
        if (wr_en) begin
            m_ready = wr_data[0];
            m_req   = wr_data[1];
        end
        m_pulse = n_pulse;
        m_seen  = n_seen;
        m_s2    = m_s1;
        m_s1    = serr_in_n;
        @(negedge clk);
        check("R2/R3 read word", rd_data, exp_word(m_ready, m_req, m_seen));
        check("R2/R3 cfg_retry", DW'(cfg_retry), DW'(!m_ready));
        check("R2/R3 devsel_allow", DW'(devsel_allow), DW'(m_ready));
        check("R4/R5 serr_out_n", DW'(serr_out_n), DW'(!m_pulse));
        check("R9 serr_irq", DW'(serr_irq), DW'(m_seen && irq_en));
        check("R6 reserved bits", DW'(rd_data[2]), '0);
    endtask

    task automatic wr(logic [3:0] d);
        wr_en = 1'b1; wr_data = d;
        step();
        wr_en = 1'b0; wr_data = '0;
    endtask

    initial begin : watchdog
        #1_000_000;
        bad++;
        total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state.
        check("R1 rd_data", rd_data, '0);
        check("R1 cfg_retry", DW'(cfg_retry), DW'(1));
        check("R1 devsel_allow", DW'(devsel_allow), '0);
        check("R1 serr_out_n", DW'(serr_out_n), DW'(1));
        check("R1 serr_irq", DW'(serr_irq), '0);
        rst_n = 1'b1;
        step();

        // R3: ready flag set, then cleared (R2).
        wr(4'b0001);
        check("R3 devsel after set", DW'(devsel_allow), DW'(1));
        wr(4'b0000);
        check("R2 retry after clear", DW'(cfg_retry), DW'(1));

        // R4: qualified request pulses once, two edges after the write.
        cmd_serr_en = 1'b1; central_fn = 1'b0;
        wr(4'b0010);
        check("R4 no pulse yet", DW'(serr_out_n), DW'(1));
        step();
        check("R4 pulse low", DW'(serr_out_n), '0);
        step();
        check("R4 pulse ends", DW'(serr_out_n), DW'(1));
        // R5: rewriting 1 gives no new pulse.
        wr(4'b0010);
        step();
        check("R5 no repeat pulse", DW'(serr_out_n), DW'(1));
        // R5: disabled reporting blocks the pulse.
        wr(4'b0000);
        cmd_serr_en = 1'b0;
        wr(4'b0010);
        step();
        check("R5 disabled no pulse", DW'(serr_out_n), DW'(1));
        wr(4'b0000);

        // R7: error seen as central function after three edges.
        central_fn = 1'b1; irq_en = 1'b1;
        serr_in_n = 1'b0;
        step(); step();
        check("R7 not yet", DW'(rd_data[3]), '0);
        serr_in_n = 1'b1;
        step();
        check("R7 seen set", DW'(rd_data[3]), DW'(1));
        check("R9 irq on", DW'(serr_irq), DW'(1));
        // R8: writing 0 keeps it, writing 1 clears it.
        wr(4'b0000);
        check("R8 write 0 keeps", DW'(rd_data[3]), DW'(1));
        wr(4'b1000);
        check("R8 clear", DW'(rd_data[3]), '0);
        // R8: set wins over clear at the same edge.
        serr_in_n = 1'b0;
        step(); step();
        wr(4'b1000);
        check("R8 set wins", DW'(rd_data[3]), DW'(1));
        serr_in_n = 1'b1;
        step(); step();
        wr(4'b1000);
        // R7: not central function, no capture.
        central_fn = 1'b0;
        serr_in_n = 1'b0;
        repeat (4) step();
        check("R7 ignored when not central", DW'(rd_data[3]), '0);
        serr_in_n = 1'b1;

        // Random mix over all inputs, checked by the model every cycle.
        for (int i = 0; i < 3000; i++) begin
            wr_en       = ($urandom % 4) == 0;
            wr_data     = 4'($urandom);
            central_fn  = ($urandom % 3) == 0;
            cmd_serr_en = ($urandom % 4) != 0;
            serr_in_n   = ($urandom % 5) != 0;
            irq_en      = ($urandom % 2) == 0;
            step();
        end
        wr_en = 1'b0;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule